// File: doc/BRIEF.md
# Clear-on-Read Masked Interrupt Status Register

This block collects single-cycle event pulses from a receiver into a sticky status register of `W` bits. A per-bit mask register, written and read back by the CPU, picks which latched bits may raise the shared interrupt line and the summary bit that a global interrupt status register gathers. When the CPU reads the status register, it receives the whole word and every bit clears in the same access.

A global visibility input changes how masked sources are handled. With visibility off, a pulse on a masked source is discarded. With visibility on, the pulse is latched so that software can poll it. Such a bit still never drives the interrupt line or the summary bit. An event that arrives in the same cycle as a clearing read is not lost: it shows up in the register after the clear.

The interrupt and summary outputs are pure functions of the two registers, so they change in the cycle after the edge that changes status or mask. The read data is registered and appears one cycle after the read strobe.

Top module: `isr_masked_status`

## Requirements
- R1: After synchronous reset the status register is all zeros, the mask register is all ones (bit value 1 = masked), the read data is zero, and the interrupt and summary outputs are low.
- R2: An event pulse on bit i with mask bit i equal to 0 sets status bit i at the next clock edge. The bit then stays set until a read.
- R3: A cycle with `stat_rd_i` high loads the current status word into `stat_rdata_o`, visible after the next edge. At the same edge every status bit clears.
- R4: An event that is accepted in the same cycle as a read is set in the status register after that edge, so the next read returns it.
- R5: With `vis_en_i` high, an event on a masked bit (mask bit = 1) is still latched into the status register.
- R6: With `vis_en_i` low, an event on a masked bit is dropped and the status register does not change for that bit.
- R7: `irq_o` is high exactly when some status bit is set whose mask bit is 0. Masked status bits never raise it.
- R8: `summary_o` follows the same rule as `irq_o`, so masked status bits are never reported in it.
- R9: A cycle with `mask_we_i` high loads `mask_wdata_i` into the mask register, visible on `mask_rdata_o` after the edge. The mask that acts on events in a cycle is the value held before that cycle's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | W | Event pulses, one per status bit |
| vis_en_i | input | 1 | Global visibility: latch masked events when high |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | W | Mask write data, 1 = masked |
| mask_rdata_o | output | W | Current mask register value |
| stat_rd_i | input | 1 | Status read strobe; clears the register |
| stat_rdata_o | output | W | Status word captured by the last read |
| irq_o | output | 1 | Active-high interrupt, OR of unmasked set bits |
| summary_o | output | 1 | Bit for the global interrupt status register |

## Verification
The bench builds the block with the default width of 8. At this width, walking single bits, mixed nibble masks and a long run of pseudo-random event, mask, visibility and read patterns reach every bit position and many mask combinations in a few hundred cycles. A behavioural model is compared with every output on every clock. Directed sequences cover the collision of an event with a clearing read and the switching of visibility while sources are masked.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned ISR_DEF_W = 8;

  function automatic logic any_pending(input logic [63:0] stat, input logic [63:0] msk);
    return |(stat & ~msk);
  endfunction
endpackage

// File: rtl/isr_mask_reg.sv
module isr_mask_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)       mask_o <= '1;
    else if (we_i) mask_o <= wdata_i;
  end

  p_mask_write_r9: assert property (@(posedge clk) disable iff (rst)
    we_i |=> mask_o == $past(wdata_i));
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_o));
endmodule

// File: rtl/isr_status_reg.sv
module isr_status_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] accept_i,
  input  logic         rd_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] base;
  logic [W-1:0] set_bits;

  assign base     = rd_i ? '0 : status_o;
  assign set_bits = evt_i & accept_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      rdata_o  <= '0;
    end else begin
      status_o <= base | set_bits;
      if (rd_i) rdata_o <= status_o;
    end
  end

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> (status_o & $past(status_o)) == $past(status_o));
  p_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_i && evt_i == '0) |=> status_o == '0);
  p_rdata_r3: assert property (@(posedge clk) disable iff (rst)
    rd_i |=> rdata_o == $past(status_o));
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_i == '0) |=> (status_o & ~$past(status_o)) == '0);
endmodule

// File: rtl/isr_irq_merge.sv
module isr_irq_merge #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o,
  output logic         summary_o
);
  logic [W-1:0] pend;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pend[i] = status_i[i] & ~mask_i[i];
  end

  assign irq_o     = |pend;
  assign summary_o = |pend;

  always_comb begin
    p_masked_quiet_r7: assert ((pend != '0) || !irq_o);
    p_summary_quiet_r8: assert ((mask_i != '1) || !summary_o);
  end
endmodule

// File: rtl/isr_masked_status.sv
module isr_masked_status #(
  parameter int unsigned W = isr_pkg::ISR_DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         vis_en_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_wdata_i,
  output logic [W-1:0] mask_rdata_o,
  input  logic         stat_rd_i,
  output logic [W-1:0] stat_rdata_o,
  output logic         irq_o,
  output logic         summary_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] status_q;
  logic [W-1:0] accept;

  assign accept       = vis_en_i ? '1 : ~mask_q;
  assign mask_rdata_o = mask_q;

  isr_mask_reg #(.W(W)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we_i), .wdata_i(mask_wdata_i), .mask_o(mask_q)
  );

  isr_status_reg #(.W(W)) u_stat (
    .clk(clk), .rst(rst), .evt_i(evt_i), .accept_i(accept), .rd_i(stat_rd_i),
    .status_o(status_q), .rdata_o(stat_rdata_o)
  );

  isr_irq_merge #(.W(W)) u_merge (
    .status_i(status_q), .mask_i(mask_q), .irq_o(irq_o), .summary_o(summary_o)
  );

  p_drop_masked_r6: assert property (@(posedge clk) disable iff (rst)
    !vis_en_i |=> ((status_q & ~$past(status_q)) & $past(mask_q)) == '0);
  p_visible_r5: assert property (@(posedge clk) disable iff (rst)
    vis_en_i |=> (status_q & $past(evt_i)) == $past(evt_i));
  p_collide_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && vis_en_i) |=> status_q == $past(evt_i));
  p_all_masked_r7: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |-> !irq_o);
endmodule

// File: tb/sim_isr_masked_status.sv
module sim_isr_masked_status;
  localparam int W = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, vis, mwe, srd, irq, summ;
  logic [W-1:0] evt, mwd, mrd, srdat;

  isr_masked_status #(.W(W)) u0 (
    .clk(clk), .rst(rst), .evt_i(evt), .vis_en_i(vis), .mask_we_i(mwe),
    .mask_wdata_i(mwd), .mask_rdata_o(mrd), .stat_rd_i(srd), .stat_rdata_o(srdat),
    .irq_o(irq), .summary_o(summ)
  );

  int tests = 0, fails = 0;
  logic [W-1:0] m_stat, m_mask, m_rdata;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic p;
    p = |(m_stat & ~m_mask);
    chk({tag, " rdata"}, srdat, m_rdata);
    chk("R7 irq", {7'd0, irq}, {7'd0, p});
    chk("R8 summary", {7'd0, summ}, {7'd0, p});
    chk("R9 mask", mrd, m_mask);
  endtask

  task automatic step(input logic [W-1:0] ev, input logic v, input logic rd,
                      input logic we, input logic [W-1:0] wd, input string tag);
    logic [W-1:0] acc;
    @(negedge clk);
    evt = ev; vis = v; srd = rd; mwe = we; mwd = wd;
    @(posedge clk);
    acc = v ? {W{1'b1}} : ~m_mask;
    if (rd) m_rdata = m_stat;
    m_stat = (rd ? '0 : m_stat) | (ev & acc);
    if (we) m_mask = wd;
    #2;
    compare_all(tag);
  endtask

  task automatic rd_check(input string tag, input logic [W-1:0] exp);
    step('0, 1'b0, 1'b1, 1'b0, '0, tag);
    step('0, 1'b0, 1'b0, 1'b0, '0, tag);
    chk(tag, srdat, exp);
  endtask

  initial begin
    #(20 * 50000);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; evt = '0; vis = 1'b0; mwe = 1'b0; mwd = '0; srd = 1'b0;
    m_stat = '0; m_mask = '1; m_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare_all("R1");
    chk("R1 mask reset", mrd, 8'hFF);

    // R9: unmask low nibble; mask from before the write acts this cycle
    step(8'h01, 1'b0, 1'b0, 1'b1, 8'hF0, "R9");
    chk("R9 old mask drops event", {7'd0, irq}, 8'd0);
    // R2: unmasked events latch and stick
    step(8'h05, 1'b0, 1'b0, 1'b0, '0, "R2");
    step('0, 1'b0, 1'b0, 1'b0, '0, "R2");
    chk("R2 irq up", {7'd0, irq}, 8'd1);
    rd_check("R3 read value", 8'h05);
    rd_check("R3 cleared", 8'h00);
    // R6: masked event dropped with visibility off
    step(8'hF0, 1'b0, 1'b0, 1'b0, '0, "R6");
    rd_check("R6 dropped", 8'h00);
    // R5: masked event visible but no interrupt
    step(8'hA0, 1'b1, 1'b0, 1'b0, '0, "R5");
    chk("R5 no irq", {7'd0, irq}, 8'd0);
    chk("R8 no summary", {7'd0, summ}, 8'd0);
    rd_check("R5 visible", 8'hA0);
    // R4: event in the same cycle as read is kept
    step(8'h01, 1'b0, 1'b0, 1'b0, '0, "R4");
    step(8'h02, 1'b0, 1'b1, 1'b0, '0, "R4");
    chk("R4 old word", srdat, 8'h01);
    rd_check("R4 kept", 8'h02);
    // walking bits with everything unmasked
    step('0, 1'b0, 1'b0, 1'b1, 8'h00, "R9");
    for (int i = 0; i < W; i++) begin
      step(8'(1 << i), 1'b0, 1'b0, 1'b0, '0, "R2");
      rd_check("R2 walk", 8'(1 << i));
    end
    // pseudo-random traffic
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[7:0], r[8], (r[11:9] == 3'd0), (r[14:12] == 3'd0), r[23:16], "R3");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule